// File: doc/BRIEF.md
# Bit-Permuted Counter PWM Generator

This block produces a pulse-width modulated bit for a downstream low-pass filter. A free-running binary counter sweeps a full frame of 2^CNT_W counts. Before it reaches the magnitude comparator, its bits are rearranged. The output is high for every count whose rearranged value is below the latched duty word. Because the rearrangement is a one-to-one mapping of the counter, the total high time per frame always equals the duty word. The order in which the high counts occur depends on the mapping, so one long pulse can be broken into many short ones. This moves the ripple to a higher frequency while keeping the number of edges fixed and small.

Four mappings are selectable:
- **Plain:** the counter is used as is, giving one pulse per frame.
- **Block reversal:** the top SEG_BITS counter bits are reversed.
- **Rotation:** the low bits move to the top of the compare word and the reversed high bits fill the bottom. This splits the high time into 2^SEG_BITS near-equal pulses.
- **Folded rotation:** like rotation, but the low bits are also XOR-folded so that each segment is shaped as an up-then-down staircase. This reduces phase modulation of the pulses by the duty value.

The duty word and the mapping are captured together only at the end of a frame. A frame is therefore always generated from a single consistent setting.

Top module: `bitperm_pwm`

## Requirements
- R1: While reset is asserted, and throughout the first frame after reset is released, pwm_o is low. The latched duty resets to 0 and the latched mode resets to plain.
- R2: The counter increments by one every clock, starting from 0 after reset. It wraps from 2^CNT_W-1 back to 0.
- R3: duty_i and mode_i are captured only on the clock edge at which the counter holds 2^CNT_W-1. They govern the frame that starts at count 0. Changes to either input at any other time have no effect on the current frame.
- R4: pwm_o is registered. It goes high on the clock edge after a count whose compare value is below the latched duty, and low otherwise. Count 0 maps to compare value 0 in every mode.
- R5: Mode 0 (plain): the compare value equals the counter. For a duty of 1 to 2^CNT_W-1, a frame holds one pulse, which is 2 transitions counted cyclically.
- R6: Mode 1 (block reversal): the compare value is the counter with its top SEG_BITS bits in reversed order. The low CNT_W-SEG_BITS bits are unchanged.
- R7: Mode 2 (rotation): the compare value is {counter[CNT_W-SEG_BITS-1:0], reversed counter[CNT_W-1:CNT_W-SEG_BITS]}. With defaults the sequence is 0, 16, 32, …, 1008, then 8, 24, ….
- R8: Mode 3 (folded rotation): as mode 2, except that each rotated low bit below the most significant low bit is first XORed with that most significant low bit.
- R9: In every mode, the number of high cycles in a frame equals the latched duty exactly.
- R10: In modes 2 and 3, for 2^SEG_BITS ≤ duty ≤ 2^CNT_W-2^SEG_BITS, a frame has exactly 2^(SEG_BITS+1) transitions, counted cyclically.
- R11: In mode 2, within that same duty range, the frame splits into 2^SEG_BITS runs of 2^(CNT_W-SEG_BITS) counts each. The high counts of these runs differ by at most one.
- R12: A duty of 0 keeps pwm_o low for the whole frame. A duty of 2^CNT_W-1 keeps it high for all but one count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| duty_i | input | CNT_W | Duty word, number of high counts per frame |
| mode_i | input | 2 | Mapping select: 0 plain, 1 block reversal, 2 rotation, 3 folded rotation |
| pwm_o | output | 1 | Registered PWM output |

## Verification
Each mode is driven with a mid-scale duty. The whole frame is compared sample by sample against the mapping. This separates the four mappings, because each places the same number of high counts in a different order. The duty extremes (0, 1, 16, 1008, 2^CNT_W-1) and random duty/mode pairs check that the high count always matches the duty. They also check that the edge count in the rotated modes stays at 32 exactly at the limits of the stated range. Frames in which the inputs are changed partway through show whether the capture happens only at the frame boundary.

// File: rtl/pwmperm_pkg.sv
package pwmperm_pkg;

    // Compare-word mapping applied to the frame counter
    typedef enum logic [1:0] {
        MAP_PLAIN  = 2'd0,
        MAP_BLKREV = 2'd1,
        MAP_ROTATE = 2'd2,
        MAP_FOLD   = 2'd3
    } pwm_map_e;

endpackage

// File: rtl/pwmperm_counter.sv
module pwmperm_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    output logic [CNT_W-1:0] cnt_o,
    output logic             frame_end_o
);
    localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        state_d.cnt = state_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cnt_o       = state_q.cnt;
    assign frame_end_o = (state_q.cnt == CNT_LAST);

endmodule

// File: rtl/pwmperm_mapper.sv
module pwmperm_mapper
    import pwmperm_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int SEG_BITS = 4
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  pwm_map_e         map_i,
    output logic [CNT_W-1:0] cmp_o
);
    localparam int LOW_W = CNT_W - SEG_BITS;

    logic [SEG_BITS-1:0] high_rev;
    logic [LOW_W-1:0]    low_bits;
    logic [LOW_W-1:0]    low_fold;

    assign low_bits = cnt_i[LOW_W-1:0];

    // Reverse the order of the top segment-select bits
    for (genvar g = 0; g < SEG_BITS; g++) begin : g_rev
        assign high_rev[g] = cnt_i[CNT_W-1-g];
    end

    // Fold the rotated bits around their most significant bit
    for (genvar g = 0; g < LOW_W - 1; g++) begin : g_fold
        assign low_fold[g] = low_bits[g] ^ low_bits[LOW_W-1];
    end
    assign low_fold[LOW_W-1] = low_bits[LOW_W-1];

    always_comb begin
        unique case (map_i)
            MAP_PLAIN:  cmp_o = cnt_i;
            MAP_BLKREV: cmp_o = {high_rev, low_bits};
            MAP_ROTATE: cmp_o = {low_bits, high_rev};
            MAP_FOLD:   cmp_o = {low_fold, high_rev};
            default:    cmp_o = cnt_i;
        endcase
    end

endmodule

// File: rtl/pwmperm_cmp.sv
module pwmperm_cmp
    import pwmperm_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             frame_end_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic [1:0]       mode_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic [CNT_W-1:0] duty_o,
    output pwm_map_e         map_o,
    output logic             pwm_o
);
    typedef struct packed {
        logic [CNT_W-1:0] duty;
        pwm_map_e         map;
        logic             pwm;
    } cmp_state_t;

    cmp_state_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        state_d.pwm = (cmp_i < state_q.duty);
        if (frame_end_i) begin
            state_d.duty = duty_i;
            state_d.map  = pwm_map_e'(mode_i);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q.duty <= '0;
            state_q.map  <= MAP_PLAIN;
            state_q.pwm  <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign duty_o = state_q.duty;
    assign map_o  = state_q.map;
    assign pwm_o  = state_q.pwm;

endmodule

// File: rtl/bitperm_pwm.sv
module bitperm_pwm
    import pwmperm_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int SEG_BITS = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] duty_i,
    input  logic [1:0]       mode_i,
    output logic             pwm_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             frame_end;
    logic [CNT_W-1:0] cmp_val;
    logic [CNT_W-1:0] duty_q;
    pwm_map_e         map_q;

    pwmperm_counter #(.CNT_W(CNT_W)) u_counter (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cnt_o       (cnt_q),
        .frame_end_o (frame_end)
    );

    pwmperm_mapper #(.CNT_W(CNT_W), .SEG_BITS(SEG_BITS)) u_mapper (
        .cnt_i (cnt_q),
        .map_i (map_q),
        .cmp_o (cmp_val)
    );

    pwmperm_cmp #(.CNT_W(CNT_W)) u_cmp (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .frame_end_i (frame_end),
        .duty_i      (duty_i),
        .mode_i      (mode_i),
        .cmp_i       (cmp_val),
        .duty_o      (duty_q),
        .map_o       (map_q),
        .pwm_o       (pwm_o)
    );

endmodule

// File: rtl/pwmperm_checker.sv
module pwmperm_checker #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] duty,
    input logic [1:0]       map,
    input logic             pwm
);
    localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cnt == CNT_W'($past(cnt) + 1'b1));

    assert_duty_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != CNT_LAST) |=> $stable(duty));

    assert_map_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != CNT_LAST) |=> $stable(map));

    assert_frame_start_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && duty != '0) |=> pwm);

    assert_zero_duty_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (duty == '0) |=> !pwm);

endmodule

bind bitperm_pwm pwmperm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk   (clk_i),
    .rst_n (rst_ni),
    .cnt   (cnt_q),
    .duty  (duty_q),
    .map   (map_q),
    .pwm   (pwm_o)
);

// File: tb/sim_bitperm_pwm.sv
module sim_bitperm_pwm;
    localparam int W     = 10;
    localparam int B     = 4;
    localparam int LW    = W - B;
    localparam int FRAME = 1 << W;
    localparam int SEGS  = 1 << B;
    localparam int RUN   = 1 << LW;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] duty_in = '0;
    logic [1:0]   mode_in = 2'd0;
    logic         pwm;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit smp [FRAME];

    always #5 clk = ~clk;

    bitperm_pwm #(.CNT_W(W), .SEG_BITS(B)) u0 (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .duty_i (duty_in),
        .mode_i (mode_in),
        .pwm_o  (pwm)
    );

    function automatic int perm(int c, int m);
        int top = c >> LW;
        int low = c & (RUN - 1);
        int rt  = 0;
        int f;
        for (int j = 0; j < B; j++) rt |= ((top >> j) & 1) << (B - 1 - j);
        f = low;
        if ((low >> (LW - 1)) & 1) f = low ^ ((RUN >> 1) - 1);
        case (m)
            0: return c;
            1: return (rt << LW) | low;
            2: return (low << B) | rt;
            default: return (f << B) | rt;
        endcase
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Load a setting, let it take effect, then capture one whole frame
    task automatic run_cfg(int d, int m, bit poke);
        int highs = 0, trans = 0, bad = 0, first_bad = -1, mn = RUN, mx = 0;
        duty_in = W'(d);
        mode_in = 2'(m);
        repeat (FRAME) @(negedge clk);
        for (int i = 0; i < FRAME; i++) begin
            @(negedge clk);
            smp[i] = pwm;
            if (poke && i == 300) begin
                duty_in = W'(d ^ 341);
                mode_in = 2'(m ^ 1);
            end
        end
        for (int i = 0; i < FRAME; i++) begin
            highs += int'(smp[i]);
            if (smp[i] != smp[(i + 1) % FRAME]) trans++;
            if (smp[i] != (perm(i, m) < d)) begin
                bad++;
                if (first_bad < 0) first_bad = i;
            end
        end
        case (m)
            0: chk(bad == 0, "R4/R5 plain sequence, first bad count", first_bad, -1);
            1: chk(bad == 0, "R4/R6 block reversal sequence, first bad count", first_bad, -1);
            2: chk(bad == 0, "R4/R7 rotation sequence, first bad count", first_bad, -1);
            default: chk(bad == 0, "R4/R8 folded sequence, first bad count", first_bad, -1);
        endcase
        chk(highs == d, "R9 high count per frame", highs, d);
        if (m == 0 && d >= 1) chk(trans == 2, "R5 plain transitions", trans, 2);
        if (m >= 2 && d >= SEGS && d <= FRAME - SEGS)
            chk(trans == 2 * SEGS, "R10 transitions per frame", trans, 2 * SEGS);
        if (m == 2 && d >= SEGS && d <= FRAME - SEGS) begin
            for (int r = 0; r < SEGS; r++) begin
                int h = 0;
                for (int j = 0; j < RUN; j++) h += int'(smp[r * RUN + j]);
                if (h < mn) mn = h;
                if (h > mx) mx = h;
            end
            chk(mx - mn <= 1, "R11 segment spread", mx - mn, 1);
        end
        if (d == 0) chk(highs == 0, "R12 zero duty highs", highs, 0);
        if (d == FRAME - 1) chk(highs == FRAME - 1, "R12 full duty highs", highs, FRAME - 1);
        if (poke) chk(bad == 0 && highs == d, "R3 mid-frame change ignored, highs", highs, d);
    endtask

    initial begin
        int hi0 = 0;
        void'($urandom(32'd2024));
        duty_in = W'(500);
        mode_in = 2'd2;
        repeat (3) @(negedge clk);
        chk(pwm == 1'b0, "R1 output low in reset", int'(pwm), 0);
        rst_n = 1'b1;
        for (int i = 0; i < FRAME; i++) begin
            @(negedge clk);
            hi0 += int'(pwm);
        end
        chk(hi0 == 0, "R1 first frame uses reset duty", hi0, 0);

        run_cfg(600, 1, 1'b0);
        run_cfg(600, 2, 1'b0);
        run_cfg(600, 3, 1'b0);
        run_cfg(300, 3, 1'b0);
        run_cfg(600, 0, 1'b0);
        run_cfg(16, 2, 1'b0);
        run_cfg(1008, 2, 1'b0);
        run_cfg(16, 3, 1'b0);
        run_cfg(1008, 3, 1'b0);
        run_cfg(1, 0, 1'b0);
        run_cfg(1023, 0, 1'b0);
        run_cfg(0, 3, 1'b0);
        run_cfg(1023, 2, 1'b0);
        run_cfg(1023, 1, 1'b0);
        run_cfg(512, 3, 1'b1);
        run_cfg(77, 2, 1'b1);
        for (int k = 0; k < 18; k++) run_cfg(int'($urandom_range(FRAME - 1, 0)), int'($urandom_range(3, 0)), k[0]);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule